// File: doc/BRIEF.md
# Serial Programming Mode Entry Sequencer

This block drives the pins a host uses to put a target microcontroller into low-voltage serial programming mode and to take it out again. It controls four target-side signals: a power enable, the active-low reset pin, a serial data line and a serial clock line. Data and clock each have an output enable so that they can be released to high impedance.

A one-cycle `start_i` pulse runs the entry sequence. All three programming pins are first driven low. Power is then applied, unless the self-powered mode is selected. After a setup delay, reset is pulsed high once and returned low. A long wait follows, and then a fixed 32-bit key is clocked out MSB first. After a short gap reset is released high, and `ready_o` rises only once the hold time has passed. A one-cycle `stop_i` pulse in the ready state runs the exit sequence, which ends with data and clock released.

Every delay is a microsecond parameter that is scaled to clock cycles by a clock-frequency parameter. The clock half-periods of the key are given directly in cycles. Command traffic after entry is handled by other logic.

Top module: `prog_entry_seq`

## Requirements
- R1: Out of reset the block is idle: `tgt_pwr_en_o`=0, `tgt_rst_o`=1, data and clock output enables 0, `tgt_dat_o`=`tgt_sck_o`=0, `busy_o`=0, `ready_o`=0.
- R2: In the cycle after a `start_i` pulse is sampled in idle, `busy_o`=1, both output enables are 1, and data, clock and reset are all 0 with power still off. This lasts one cycle. Power then turns on for a setup period of T_SETUP_US×CLK_FREQ_MHZ cycles while reset stays low.
- R3: Reset is then driven high for T_PULSE_US×CLK_FREQ_MHZ cycles and low again for T_KEYWAIT_US×CLK_FREQ_MHZ cycles before the key starts. The serial clock is never high while reset is high during entry.
- R4: The key phase produces 32 clock pulses. Each pulse is SCK_HALF_CYC cycles low followed by SCK_HALF_CYC cycles high. Data is stable across every rising edge, and the bits taken at the rising edges, MSB first, form 0x4D434850.
- R5: After the last clock falls, reset stays low for T_KEYGAP_US×CLK_FREQ_MHZ cycles and then goes high for T_HOLD_US×CLK_FREQ_MHZ cycles. After that, `ready_o`=1 and `busy_o`=0, with reset high and data and clock driven low.
- R6: A `start_i` pulse while busy or ready is ignored. The sequence in progress keeps its timing and the ready state is kept.
- R7: A `stop_i` pulse in ready drives data and clock low with reset high for T_EXGAP_US×CLK_FREQ_MHZ cycles. Reset is then low for T_EXHOLD_US×CLK_FREQ_MHZ cycles. After that the block is idle again: power off, reset high, data and clock enables 0, `busy_o`=0.
- R8: When `self_pwr_i`=1 is sampled with `start_i`, `tgt_pwr_en_o` stays 0 through entry, ready and exit, and all other timing is unchanged.
- R9: A `stop_i` pulse in idle or during entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to run the entry sequence |
| stop_i | input | 1 | One-cycle request to run the exit sequence |
| self_pwr_i | input | 1 | Sampled with start: 1 leaves the power pin alone |
| tgt_pwr_en_o | output | 1 | Target power enable |
| tgt_rst_o | output | 1 | Level of the target's active-low reset pin |
| tgt_dat_o | output | 1 | Serial data value |
| tgt_dat_oe_o | output | 1 | Serial data output enable |
| tgt_sck_o | output | 1 | Serial clock value |
| tgt_sck_oe_o | output | 1 | Serial clock output enable |
| busy_o | output | 1 | Entry or exit sequence in progress |
| ready_o | output | 1 | Target is in programming mode |

## Verification
All outputs are decoded from registered state, so a request pulse sampled at one rising edge shows its first effect in the cycle right after that edge. Each later phase then lasts exactly its parameter count in cycles. The bench drives inputs and samples outputs on falling edges. It walks through the expected timeline phase by phase, comparing every sampled cycle against the level that phase requires, so a phase that is one cycle short or long shows up as a mismatch at the boundary. In the key phase the bench takes data in the first high cycle of each clock pulse and checks it against the previous cycle. Stray start and stop pulses are injected in the middle of a phase, and the rest of that timeline is still checked unchanged.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;

  localparam int unsigned KEY_W = 32;
  localparam logic [KEY_W-1:0] ENTRY_KEY = 32'h4D43_4850;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_PULSE,
    ST_KWAIT,
    ST_KEY,
    ST_GAP,
    ST_HOLD,
    ST_READY,
    ST_XLOW,
    ST_XRST
  } seq_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned us2cyc(input int unsigned us, input int unsigned mhz);
    return (us * mhz < 1) ? 1 : us * mhz;
  endfunction

endpackage

// File: rtl/prog_entry_rst_sync.sv
module prog_entry_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/prog_entry_timer.sv
module prog_entry_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: an unloaded, nonzero count steps down by exactly one
  p_tick_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prog_entry_keyshift.sv
module prog_entry_keyshift #(
  parameter int unsigned          KEY_W    = 32,
  parameter logic [KEY_W-1:0]     KEY      = '0,
  parameter int unsigned          HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic sdo_o,
  output logic sck_o,
  output logic done_o
);

  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned BW = $clog2(KEY_W + 1);

  logic [KEY_W-1:0] sh_q, sh_d;
  logic [HW-1:0]    half_q, half_d;
  logic [BW-1:0]    bits_q, bits_d;
  logic             sck_q, sck_d;
  logic             upd;

  always_comb begin
    sh_d   = sh_q;
    half_d = half_q;
    bits_d = bits_q;
    sck_d  = sck_q;
    upd    = load_i || en_i;
    if (load_i) begin
      sh_d   = KEY;
      half_d = HW'(HALF_CYC - 1);
      bits_d = BW'(KEY_W);
      sck_d  = 1'b0;
    end else if (en_i) begin
      if (half_q != '0) begin
        half_d = half_q - 1'b1;
      end else begin
        half_d = HW'(HALF_CYC - 1);
        if (!sck_q) begin
          sck_d = 1'b1;
        end else begin
          sck_d  = 1'b0;
          sh_d   = {sh_q[KEY_W-2:0], 1'b0};
          bits_d = bits_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      half_q <= '0;
      bits_q <= '0;
      sck_q  <= 1'b0;
    end else if (upd) begin
      sh_q   <= sh_d;
      half_q <= half_d;
      bits_q <= bits_d;
      sck_q  <= sck_d;
    end
  end

  assign sdo_o  = sh_q[KEY_W-1];
  assign sck_o  = sck_q;
  assign done_o = en_i && sck_q && (half_q == '0) && (bits_q == BW'(1));

  // R4: the data bit does not change on the cycle the clock rises
  p_dat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(sh_q[KEY_W-1]));

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq #(
  parameter int unsigned CLK_FREQ_MHZ = 200,
  parameter int unsigned T_SETUP_US   = 1,
  parameter int unsigned T_PULSE_US   = 1,
  parameter int unsigned T_KEYWAIT_US = 4000,
  parameter int unsigned T_KEYGAP_US  = 1,
  parameter int unsigned T_HOLD_US    = 400,
  parameter int unsigned T_EXGAP_US   = 1,
  parameter int unsigned T_EXHOLD_US  = 3,
  parameter int unsigned SCK_HALF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic self_pwr_i,
  output logic tgt_pwr_en_o,
  output logic tgt_rst_o,
  output logic tgt_dat_o,
  output logic tgt_dat_oe_o,
  output logic tgt_sck_o,
  output logic tgt_sck_oe_o,
  output logic busy_o,
  output logic ready_o
);

  import prog_entry_pkg::*;

  localparam int unsigned C_SETUP  = us2cyc(T_SETUP_US,   CLK_FREQ_MHZ);
  localparam int unsigned C_PULSE  = us2cyc(T_PULSE_US,   CLK_FREQ_MHZ);
  localparam int unsigned C_KWAIT  = us2cyc(T_KEYWAIT_US, CLK_FREQ_MHZ);
  localparam int unsigned C_GAP    = us2cyc(T_KEYGAP_US,  CLK_FREQ_MHZ);
  localparam int unsigned C_HOLD   = us2cyc(T_HOLD_US,    CLK_FREQ_MHZ);
  localparam int unsigned C_XGAP   = us2cyc(T_EXGAP_US,   CLK_FREQ_MHZ);
  localparam int unsigned C_XHOLD  = us2cyc(T_EXHOLD_US,  CLK_FREQ_MHZ);
  localparam int unsigned C_MAX    = umax(umax(umax(C_SETUP, C_PULSE), umax(C_KWAIT, C_GAP)),
                                          umax(umax(C_HOLD, C_XGAP), C_XHOLD));
  localparam int unsigned CNT_W    = $clog2(C_MAX + 1);
  localparam int unsigned HALF_CYC = (SCK_HALF_CYC < 1) ? 1 : SCK_HALF_CYC;

  logic             rst_n_s;
  seq_state_e       st_q, st_d;
  logic             self_q, self_d;
  logic             pwr_q, pwr_d;
  logic             tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             key_ld, key_en, key_sdo, key_sck, key_done;

  prog_entry_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  prog_entry_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  prog_entry_keyshift #(
    .KEY_W    (KEY_W),
    .KEY      (ENTRY_KEY),
    .HALF_CYC (HALF_CYC)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (key_ld),
    .en_i   (key_en),
    .sdo_o  (key_sdo),
    .sck_o  (key_sck),
    .done_o (key_done)
  );

  assign key_en = (st_q == ST_KEY);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    self_d  = self_q;
    pwr_d   = pwr_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    key_ld  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_PRE;
        self_d = self_pwr_i;
        tmr_ld = 1'b1;
      end
      ST_PRE: if (tmr_zero) begin
        st_d    = ST_SETUP;
        pwr_d   = !self_q;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_SETUP - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        st_d    = ST_PULSE;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_PULSE - 1);
      end
      ST_PULSE: if (tmr_zero) begin
        st_d    = ST_KWAIT;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_KWAIT - 1);
      end
      ST_KWAIT: if (tmr_zero) begin
        st_d   = ST_KEY;
        key_ld = 1'b1;
      end
      ST_KEY: if (key_done) begin
        st_d    = ST_GAP;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_GAP - 1);
      end
      ST_GAP: if (tmr_zero) begin
        st_d    = ST_HOLD;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_HOLD - 1);
      end
      ST_HOLD: if (tmr_zero) st_d = ST_READY;
      ST_READY: if (stop_i) begin
        st_d    = ST_XLOW;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_XGAP - 1);
      end
      ST_XLOW: if (tmr_zero) begin
        st_d    = ST_XRST;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(C_XHOLD - 1);
      end
      ST_XRST: if (tmr_zero) begin
        st_d  = ST_IDLE;
        pwr_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      self_q <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      self_q <= self_d;
      pwr_q  <= pwr_d;
    end
  end

  // pin decode
  always_comb begin
    tgt_pwr_en_o = pwr_q;
    tgt_dat_oe_o = (st_q != ST_IDLE);
    tgt_sck_oe_o = (st_q != ST_IDLE);
    tgt_dat_o    = (st_q == ST_KEY) && key_sdo;
    tgt_sck_o    = (st_q == ST_KEY) && key_sck;
    tgt_rst_o    = (st_q == ST_IDLE) || (st_q == ST_PULSE) || (st_q == ST_HOLD) ||
                   (st_q == ST_READY) || (st_q == ST_XLOW);
    busy_o       = (st_q != ST_IDLE) && (st_q != ST_READY);
    ready_o      = (st_q == ST_READY);
  end

  // R3: the key clock only runs while the target is held in reset
  p_sck_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    tgt_sck_o |-> !tgt_rst_o);

  // R5: ready is entered straight out of a cycle with reset released
  p_ready_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ready_o) |-> $past(tgt_rst_o) && tgt_rst_o && tgt_dat_oe_o && !tgt_sck_o);

  // R7: the pins are released only after a cycle with reset low
  p_release_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(tgt_dat_oe_o) |-> $past(!tgt_rst_o) && !tgt_pwr_en_o);

  // R8: a self-powered session never enables target power
  p_self_no_power_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (self_q && st_q != ST_IDLE) |-> !tgt_pwr_en_o);

endmodule

// File: tb/prog_entry_seq_tb_top.sv
module prog_entry_seq_tb_top;

  localparam int MHZ  = 200;
  localparam int HALF = 3;
  localparam int C_SETUP = 1 * MHZ;
  localparam int C_PULSE = 1 * MHZ;
  localparam int C_KWAIT = 8 * MHZ;
  localparam int C_GAP   = 1 * MHZ;
  localparam int C_HOLD  = 4 * MHZ;
  localparam int C_XGAP  = 1 * MHZ;
  localparam int C_XHOLD = 3 * MHZ;
  localparam logic [31:0] KEY = 32'h4D43_4850;

  logic clk, rst_n, start_i, stop_i, self_pwr_i;
  logic pwr, rst_pin, dat, dat_oe, sck, sck_oe, busy, ready;
  int   n_chk, n_fail;
  logic done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  prog_entry_seq #(
    .CLK_FREQ_MHZ (MHZ), .T_SETUP_US (1), .T_PULSE_US (1), .T_KEYWAIT_US (8),
    .T_KEYGAP_US (1), .T_HOLD_US (4), .T_EXGAP_US (1), .T_EXHOLD_US (3),
    .SCK_HALF_CYC (HALF)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
    .self_pwr_i (self_pwr_i), .tgt_pwr_en_o (pwr), .tgt_rst_o (rst_pin),
    .tgt_dat_o (dat), .tgt_dat_oe_o (dat_oe), .tgt_sck_o (sck),
    .tgt_sck_oe_o (sck_oe), .busy_o (busy), .ready_o (ready)
  );

  // Checks a phase of n sampled cycles; optionally injects a stray request.
  task automatic phase(input int n, input logic e_rst, input logic e_pwr, input logic e_oe,
                       input logic e_busy, input logic e_ready, input string req,
                       input bit poke_start, input bit poke_stop);
    int bad = 0;
    logic [7:0] act = '0, exp = '0;
    for (int i = 0; i < n; i++) begin
      if ({rst_pin, pwr, dat_oe, sck_oe, busy, ready, sck, dat} !=
          {e_rst, e_pwr, e_oe, e_oe, e_busy, e_ready, 1'b0, 1'b0} && bad == 0) begin
        bad = i + 1;
        act = {rst_pin, pwr, dat_oe, sck_oe, busy, ready, sck, dat};
        exp = {e_rst, e_pwr, e_oe, e_oe, e_busy, e_ready, 1'b0, 1'b0};
      end
      if (i == 1) begin start_i = poke_start; stop_i = poke_stop; end
      if (i == 2) begin start_i = 1'b0; stop_i = 1'b0; end
      @(negedge clk);
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: cycle %0d of %0d pins {rst,pwr,doe,coe,busy,rdy,sck,dat} actual %b expected %b",
               req, bad - 1, n, act, exp);
    end
  endtask

  task automatic pulse_start(input logic self);
    self_pwr_i = self;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_entry(input logic self, input bit poke_start, input bit poke_stop);
    logic p = !self;
    string pr = self ? "R8" : "R2";
    logic [31:0] got = '0;
    int bad = 0;
    logic prev_dat = 1'b0;
    pulse_start(self);
    phase(1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R2", 0, 0);
    phase(C_SETUP, 1'b0, p, 1'b1, 1'b1, 1'b0, pr, 0, 0);
    phase(C_PULSE, 1'b1, p, 1'b1, 1'b1, 1'b0, "R3", 0, 0);
    phase(C_KWAIT, 1'b0, p, 1'b1, 1'b1, 1'b0, poke_start ? "R6" : (poke_stop ? "R9" : "R3"),
          poke_start, poke_stop);
    for (int j = 0; j < 64 * HALF; j++) begin
      if (sck != ((j % (2 * HALF)) >= HALF) || rst_pin || pwr != p || !busy || ready) bad++;
      if ((j % (2 * HALF)) == HALF) begin
        got = {got[30:0], dat};
        if (dat != prev_dat) bad++;
      end
      prev_dat = dat;
      @(negedge clk);
    end
    n_chk++;
    if (got != KEY || bad != 0) begin
      n_fail++;
      $display("FAIL R4: key actual %h expected %h, %0d timing errors (expected 0)", got, KEY, bad);
    end
    phase(C_GAP, 1'b0, p, 1'b1, 1'b1, 1'b0, "R5", 0, 0);
    phase(C_HOLD, 1'b1, p, 1'b1, 1'b1, 1'b0, "R5", 0, 0);
    phase(2, 1'b1, p, 1'b1, 1'b0, 1'b1, self ? "R8" : "R5", 0, 0);
  endtask

  task automatic run_exit(input logic self);
    logic p = !self;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    phase(C_XGAP, 1'b1, p, 1'b1, 1'b1, 1'b0, "R7", 0, 0);
    phase(C_XHOLD, 1'b0, p, 1'b1, 1'b1, 1'b0, "R7", 0, 0);
    phase(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7", 0, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; self_pwr_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pins after reset
    phase(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1", 0, 0);
    // R9: stop in idle has no effect
    phase(8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9", 0, 1);
    // R2..R5 powered entry, R6 start while ready, R7 exit
    run_entry(1'b0, 0, 0);
    phase(6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6", 1, 0);
    run_exit(1'b0);
    // R8 self-powered entry with a stray start during the wait (R6)
    run_entry(1'b1, 1, 0);
    run_exit(1'b1);
    // R9: stop during entry is ignored
    run_entry(1'b0, 0, 1);
    run_exit(1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule